// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block collects the event pulses of a CAN controller into a set of interrupt flags and drives a single interrupt request to the system interrupt controller. The events are the end of a reset, bus activity seen during sleep, the two error-counter thresholds, and receive complete, transmit complete and transmit cancel for each mailbox. Software reads the flags over a small byte/word register interface and clears a flag by writing 1 to its bit. A mask register hides flag groups from the interrupt request. The reset flag has no mask bit.

A separate mask holds one bit per mailbox. A mailbox whose bit is set never has its receive, transmit or cancel flags set; the event is dropped, not just hidden. Mailbox 0 receives only. When its DMA mode is enabled, a reception there raises a one-cycle DMA request, sets no flag and sends nothing to the interrupt controller. Every register returns to its default while the standby input is high. The reset flag is therefore set again on the way out of standby.

Top module: `can_irq_flags`

## Requirements
- R1: After reset the event flag register (offset 0x0) reads 0x0001, the group mask (0x2) reads 0x007E, the mailbox mask (0x4) reads all ones for the implemented mailboxes, the DMA control register (0xE) reads 0, and `irq` is high.
- R2: Bit 0 of the event flag register is the reset flag. It has no mask: writing bit 0 of the group mask has no effect, and that bit reads 0. While the reset flag is set, `irq` is high. Writing 1 to bit 0 of the flag register clears it.
- R3: Bit 1 of the event flag register is set by a `bus_act_evt` pulse only while `ctrl_sleep` is high. The pulse has no effect otherwise.
- R4: Bit n of the receive (0x6), transmit-done (0x8) and cancel (0xA) registers is set by the matching event of mailbox n, unless bit n of the mailbox mask is set. A masked event is dropped and does not appear after a later unmask. Bits 2, 3 and 4 of the flag register are the OR of the receive, transmit-done and cancel registers. Writes to these three bits have no effect.
- R5: `err_warn_evt` sets bit 5 and `err_pass_evt` sets bit 6 of the event flag register.
- R6: `irq` is the reset flag ORed with each of flag bits 1 to 6 whose group mask bit is 0.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an event sets the same bit in the cycle of the clearing write, the bit stays set.
- R8: When bit 0 of register 0xE is 1, `rx_evt[0]` sets no flag and makes `dma_req` high for exactly the following cycle. When that bit is 0, `dma_req` stays low.
- R9: `bus_size` 0 is a byte access, with `bus_addr[0]` choosing the low (0) or high (1) byte. The write data is taken from `bus_wdata[7:0]`, and a read returns the byte in `bus_rdata[7:0]`. `bus_size` 1 is a word access covering both bytes.
- R10: `bus_size` 2 (longword) and 3 are rejected: they write nothing, and `bus_rdata` reads 0.
- R11: The read-only status register (0xC) has bit 0 = `ctrl_sleep` OR `ctrl_init` and bit 1 = `ctrl_sleep`.
- R12: While `standby` is high, all registers hold their R1 defaults and events are ignored. After `standby` falls, the reset flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby state: hold every register at its default |
| ctrl_sleep | input | 1 | Controller is in sleep mode |
| ctrl_init | input | 1 | Controller is in its reset/configuration state |
| bus_act_evt | input | 1 | Bus activity pulse |
| rx_evt | input | NUM_MBOX | Per-mailbox receive-complete pulses |
| txd_evt | input | NUM_MBOX | Per-mailbox transmit-complete pulses |
| txc_evt | input | NUM_MBOX | Per-mailbox transmit-cancel pulses |
| err_warn_evt | input | 1 | Error counter reached the warning level |
| err_pass_evt | input | 1 | Error counter reached the passive level |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword, 3 reserved |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | DMA request for mailbox 0 reception |

## Verification
On every cycle the assertions check four things: the reset flag always drives `irq`; the bus-activity flag can only rise during sleep; a masked mailbox never gains a flag; and an event wins over a same-cycle clear. They also check the DMA pulse and the absence of a mailbox-0 flag in DMA mode, the silence of longword accesses, and the defaults under standby. Some behaviour only the bench scenarios can show: byte-lane placement, that a dropped event stays dropped after an unmask, the status bits, the summary bits and read-only bits of the flag register, and the full mask-to-`irq` mapping.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   localparam int REG_W = 16;
   localparam int NREG  = 8;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_WORD = 2'd1,
      ACC_LONG = 2'd2,
      ACC_RSVD = 2'd3
   } acc_size_e;

   // word index = byte address bits [3:1]
   localparam logic [2:0] IX_FLAG   = 3'd0;
   localparam logic [2:0] IX_FMASK  = 3'd1;
   localparam logic [2:0] IX_MBMASK = 3'd2;
   localparam logic [2:0] IX_RXF    = 3'd3;
   localparam logic [2:0] IX_TXF    = 3'd4;
   localparam logic [2:0] IX_CXF    = 3'd5;
   localparam logic [2:0] IX_STAT   = 3'd6;
   localparam logic [2:0] IX_DMA    = 3'd7;

   // flag register bit positions
   localparam int B_RST  = 0;
   localparam int B_WAKE = 1;
   localparam int B_RXS  = 2;
   localparam int B_TXS  = 3;
   localparam int B_CXS  = 4;
   localparam int B_WARN = 5;
   localparam int B_PASS = 6;

   localparam logic [REG_W-1:0] FMASK_DEF = 16'h007E;
endpackage

// File: rtl/can_irq_flagbank.sv
// Write-1-to-clear flag bank; a set in the same cycle as a clear wins.
module can_irq_flagbank #(
   parameter int             W       = 4,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("can_irq_flagbank: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (init) q <= RST_VAL;
      else           q <= set | (q & ~clr);
   end
endmodule

// File: rtl/can_irq_maskreg.sv
// Byte-lane writable control register with a default value.
module can_irq_maskreg #(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] bmask,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("can_irq_maskreg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (init) q <= RST_VAL;
      else if (we)   q <= (q & ~bmask) | (wdata & bmask);
   end
endmodule

// File: rtl/can_irq_regif.sv
// Register access decode: sizes, byte lanes, write strobes and read mux.
module can_irq_regif
   import can_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NR     = NREG
) (
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_size,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   input  logic [NR*REG_W-1:0]  rd_vec,
   output logic [NR-1:0]        wr_hit,
   output logic [REG_W-1:0]     wr_data,
   output logic [REG_W-1:0]     wr_bmask,
   output logic [REG_W-1:0]     bus_rdata
);
   localparam int IX_W = $clog2(NR);

   logic            upper_ok;
   logic            size_ok;
   logic            is_byte;
   logic            acc_ok;
   logic            lane_hi;
   logic [IX_W-1:0] idx;
   logic [REG_W-1:0] word_rd;

   generate
      if (ADDR_W < IX_W + 1) begin : g_bad_aw
         $error("can_irq_regif: ADDR_W too small for the register count");
      end
      if (ADDR_W > IX_W + 1) begin : g_upper
         assign upper_ok = ~|bus_addr[ADDR_W-1:IX_W+1];
      end else begin : g_no_upper
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign is_byte = (bus_size == ACC_BYTE);
   assign size_ok = is_byte || (bus_size == ACC_WORD);
   assign acc_ok  = bus_sel && upper_ok && size_ok;
   assign lane_hi = bus_addr[0];
   assign idx     = bus_addr[IX_W:1];

   assign wr_data  = is_byte ? {2{bus_wdata[7:0]}} : bus_wdata;
   assign wr_bmask = is_byte ? (lane_hi ? 16'hFF00 : 16'h00FF) : 16'hFFFF;

   generate
      for (genvar k = 0; k < NR; k++) begin : g_hit
         assign wr_hit[k] = acc_ok && bus_wr && (idx == IX_W'(k));
      end
   endgenerate

   always_comb begin
      word_rd = rd_vec[int'(idx)*REG_W +: REG_W];
      if (!acc_ok || bus_wr)  bus_rdata = '0;
      else if (!is_byte)      bus_rdata = word_rd;
      else if (lane_hi)       bus_rdata = {8'h00, word_rd[15:8]};
      else                    bus_rdata = {8'h00, word_rd[7:0]};
   end
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
   import can_irq_pkg::*;
#(
   parameter int NUM_MBOX = 16,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                standby,
   input  logic                ctrl_sleep,
   input  logic                ctrl_init,
   input  logic                bus_act_evt,
   input  logic [NUM_MBOX-1:0] rx_evt,
   input  logic [NUM_MBOX-1:0] txd_evt,
   input  logic [NUM_MBOX-1:0] txc_evt,
   input  logic                err_warn_evt,
   input  logic                err_pass_evt,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [1:0]          bus_size,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   output logic                irq,
   output logic                dma_req
);
   localparam int MB_PAD = REG_W - NUM_MBOX;

   generate
      if (NUM_MBOX < 1 || NUM_MBOX > REG_W) begin : g_bad_mb
         $error("can_irq_flags: NUM_MBOX must be 1..16");
      end
   endgenerate

   logic [NREG-1:0]        wr_hit;
   logic [REG_W-1:0]       wr_data, wr_bmask;
   logic [NREG*REG_W-1:0]  rd_vec;

   can_irq_regif #(.ADDR_W(ADDR_W), .NR(NREG)) u_regif (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_size (bus_size),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .rd_vec   (rd_vec),
      .wr_hit   (wr_hit),
      .wr_data  (wr_data),
      .wr_bmask (wr_bmask),
      .bus_rdata(bus_rdata)
   );

   // write-1-to-clear vectors
   logic [REG_W-1:0] clr_main, clr_rx, clr_txd, clr_txc;
   assign clr_main = wr_hit[IX_FLAG] ? (wr_data & wr_bmask) : '0;
   assign clr_rx   = wr_hit[IX_RXF]  ? (wr_data & wr_bmask) : '0;
   assign clr_txd  = wr_hit[IX_TXF]  ? (wr_data & wr_bmask) : '0;
   assign clr_txc  = wr_hit[IX_CXF]  ? (wr_data & wr_bmask) : '0;

   // control registers
   logic [5:0]          fmask_q;
   logic [NUM_MBOX-1:0] mbmask_q;
   logic                dma_en_q;

   can_irq_maskreg #(.W(6), .RST_VAL(FMASK_DEF[6:1])) u_fmask (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .we(wr_hit[IX_FMASK]), .wdata(wr_data[6:1]), .bmask(wr_bmask[6:1]),
      .q(fmask_q)
   );

   can_irq_maskreg #(.W(NUM_MBOX), .RST_VAL({NUM_MBOX{1'b1}})) u_mbmask (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .we(wr_hit[IX_MBMASK]), .wdata(wr_data[NUM_MBOX-1:0]),
      .bmask(wr_bmask[NUM_MBOX-1:0]), .q(mbmask_q)
   );

   can_irq_maskreg #(.W(1), .RST_VAL(1'b0)) u_dma_en (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .we(wr_hit[IX_DMA]), .wdata(wr_data[0]), .bmask(wr_bmask[0]),
      .q(dma_en_q)
   );

   // event flags of the main register: {pass, warn, wake, rst}
   logic [3:0] ev_q, ev_set, ev_clr;
   assign ev_set = {err_pass_evt, err_warn_evt, bus_act_evt & ctrl_sleep, 1'b0};
   assign ev_clr = {clr_main[B_PASS], clr_main[B_WARN], clr_main[B_WAKE], clr_main[B_RST]};

   can_irq_flagbank #(.W(4), .RST_VAL(4'b0001)) u_evflags (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .set(ev_set), .clr(ev_clr), .q(ev_q)
   );

   // per-mailbox flags; masked mailboxes never set, DMA mode steals mailbox 0
   logic [NUM_MBOX-1:0] rx_q, txd_q, txc_q;
   logic [NUM_MBOX-1:0] dma_steal;
   assign dma_steal = NUM_MBOX'(dma_en_q);

   can_irq_flagbank #(.W(NUM_MBOX)) u_rxflags (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .set(rx_evt & ~mbmask_q & ~dma_steal),
      .clr(clr_rx[NUM_MBOX-1:0]), .q(rx_q)
   );

   can_irq_flagbank #(.W(NUM_MBOX)) u_txdflags (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .set(txd_evt & ~mbmask_q),
      .clr(clr_txd[NUM_MBOX-1:0]), .q(txd_q)
   );

   can_irq_flagbank #(.W(NUM_MBOX)) u_txcflags (
      .clk(clk), .rst_n(rst_n), .init(standby),
      .set(txc_evt & ~mbmask_q),
      .clr(clr_txc[NUM_MBOX-1:0]), .q(txc_q)
   );

   // DMA request: one cycle per accepted mailbox-0 reception
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dma_req <= 1'b0;
      else if (standby) dma_req <= 1'b0;
      else              dma_req <= dma_en_q & rx_evt[0];
   end

   // read views
   logic [REG_W-1:0] flag_rd, fmask_rd, mbmask_rd, rx_rd, txd_rd, txc_rd, stat_rd, dma_rd;

   generate
      if (MB_PAD > 0) begin : g_pad
         assign mbmask_rd = {{MB_PAD{1'b0}}, mbmask_q};
         assign rx_rd     = {{MB_PAD{1'b0}}, rx_q};
         assign txd_rd    = {{MB_PAD{1'b0}}, txd_q};
         assign txc_rd    = {{MB_PAD{1'b0}}, txc_q};
      end else begin : g_full
         assign mbmask_rd = mbmask_q;
         assign rx_rd     = rx_q;
         assign txd_rd    = txd_q;
         assign txc_rd    = txc_q;
      end
   endgenerate

   assign flag_rd  = {9'd0, ev_q[3], ev_q[2], |txc_q, |txd_q, |rx_q, ev_q[1], ev_q[0]};
   assign fmask_rd = {9'd0, fmask_q, 1'b0};
   assign stat_rd  = {14'd0, ctrl_sleep, ctrl_sleep | ctrl_init};
   assign dma_rd   = {15'd0, dma_en_q};

   assign rd_vec = {dma_rd, stat_rd, txc_rd, txd_rd, rx_rd, mbmask_rd, fmask_rd, flag_rd};

   // reset flag is unmaskable; bits 1..6 pass through the group mask
   assign irq = ev_q[0] | (|(flag_rd[B_PASS:B_WAKE] & ~fmask_q));

   logic unused_bits;
   assign unused_bits = &{1'b0, wr_hit[IX_STAT], clr_main[15:7], clr_main[4:2],
                          clr_rx, clr_txd, clr_txc, wr_data[15:7], wr_bmask[15:7]};
endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk
   import can_irq_pkg::*;
#(
   parameter int NUM_MBOX = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                standby,
   input logic                ctrl_sleep,
   input logic                bus_act_evt,
   input logic [NUM_MBOX-1:0] rx_evt,
   input logic                err_warn_evt,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [1:0]          bus_size,
   input logic [REG_W-1:0]    bus_rdata,
   input logic                irq,
   input logic                dma_req,
   input logic [REG_W-1:0]    flag_rd,
   input logic [5:0]          fmask_q,
   input logic [NUM_MBOX-1:0] mbmask_q,
   input logic                dma_en_q,
   input logic [NUM_MBOX-1:0] rx_q,
   input logic [NUM_MBOX-1:0] txd_q,
   input logic [NUM_MBOX-1:0] txc_q
);
   p_rst_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flag_rd[B_RST] |-> irq);

   p_wake_only_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_rd[B_WAKE] && !(bus_act_evt && ctrl_sleep)) |=> !flag_rd[B_WAKE]);

   p_mbmask_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !standby |=> ((rx_q & ~$past(rx_q) & $past(mbmask_q)) == '0));

   p_mbmask_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !standby |=> (((txd_q & ~$past(txd_q)) | (txc_q & ~$past(txc_q))) & $past(mbmask_q)) == '0);

   p_warn_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_warn_evt && !standby) |=> flag_rd[B_WARN]);

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_act_evt && ctrl_sleep && !standby) |=> flag_rd[B_WAKE]);

   p_dma_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en_q && rx_evt[0] && !standby) |=> dma_req);

   p_dma_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en_q && !standby) |=> !$rose(rx_q[0]));

   p_dma_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en_q |=> !dma_req);

   p_long_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_size == ACC_LONG) |-> (bus_rdata == '0));

   p_long_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_size == ACC_LONG && !standby)
      |=> ($stable(fmask_q) && $stable(mbmask_q) && $stable(dma_en_q)));

   p_standby_defaults_r12: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (flag_rd[B_RST] && fmask_q == FMASK_DEF[6:1]
                   && mbmask_q == '1 && !dma_en_q && !dma_req));
endmodule

bind can_irq_flags can_irq_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .standby     (standby),
   .ctrl_sleep  (ctrl_sleep),
   .bus_act_evt (bus_act_evt),
   .rx_evt      (rx_evt),
   .err_warn_evt(err_warn_evt),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_size    (bus_size),
   .bus_rdata   (bus_rdata),
   .irq         (irq),
   .dma_req     (dma_req),
   .flag_rd     (flag_rd),
   .fmask_q     (fmask_q),
   .mbmask_q    (mbmask_q),
   .dma_en_q    (dma_en_q),
   .rx_q        (rx_q),
   .txd_q       (txd_q),
   .txc_q       (txc_q)
);

// File: tb/tb_can_irq_flags.sv
module tb_can_irq_flags;
   localparam int NMB = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            standby = 1'b0, ctrl_sleep = 1'b0, ctrl_init = 1'b0;
   logic            bus_act_evt = 1'b0, err_warn_evt = 1'b0, err_pass_evt = 1'b0;
   logic [NMB-1:0]  rx_evt = '0, txd_evt = '0, txc_evt = '0;
   logic            bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]      bus_size = 2'd1;
   logic [3:0]      bus_addr = '0;
   logic [15:0]     bus_wdata = '0;
   logic [15:0]     bus_rdata;
   logic            irq, dma_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   can_irq_flags #(.NUM_MBOX(NMB), .ADDR_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .ctrl_sleep(ctrl_sleep), .ctrl_init(ctrl_init),
      .bus_act_evt(bus_act_evt), .rx_evt(rx_evt), .txd_evt(txd_evt), .txc_evt(txc_evt),
      .err_warn_evt(err_warn_evt), .err_pass_evt(err_pass_evt),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
   );

   task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [1:0] sz, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [1:0] sz, input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_size = sz; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
      logic [15:0] v;
      bread(2'd1, a, v);
      check16(tag, v, exp);
   endtask

   // {wr, size, addr, data, expected, requirement}
   localparam int NV = 18;
   localparam logic [42:0] VEC [NV] = '{
      {1'b0, 2'd1, 4'h0, 16'h0000, 16'h0001, 4'd1},   // R1 flag default
      {1'b0, 2'd1, 4'h2, 16'h0000, 16'h007E, 4'd1},   // R1 group mask default
      {1'b0, 2'd1, 4'h4, 16'h0000, 16'hFFFF, 4'd1},   // R1 mailbox mask default
      {1'b0, 2'd1, 4'hE, 16'h0000, 16'h0000, 4'd1},   // R1 DMA off
      {1'b1, 2'd0, 4'h4, 16'h00F0, 16'h0000, 4'd9},   // R9 low byte write
      {1'b0, 2'd1, 4'h4, 16'h0000, 16'hFFF0, 4'd9},
      {1'b1, 2'd0, 4'h5, 16'h0012, 16'h0000, 4'd9},   // R9 high byte from wdata[7:0]
      {1'b0, 2'd0, 4'h5, 16'h0000, 16'h0012, 4'd9},   // R9 high byte read
      {1'b0, 2'd0, 4'h4, 16'h0000, 16'h00F0, 4'd9},   // R9 low byte read
      {1'b1, 2'd2, 4'h4, 16'h0000, 16'h0000, 4'd10},  // R10 longword write
      {1'b0, 2'd1, 4'h4, 16'h0000, 16'h12F0, 4'd10},  // R10 unchanged
      {1'b0, 2'd2, 4'h4, 16'h0000, 16'h0000, 4'd10},  // R10 longword read zero
      {1'b1, 2'd1, 4'h2, 16'h007F, 16'h0000, 4'd2},   // R2 try to mask reset flag
      {1'b0, 2'd1, 4'h2, 16'h0000, 16'h007E, 4'd2},
      {1'b1, 2'd1, 4'h0, 16'h0001, 16'h0000, 4'd2},   // R2 clear reset flag
      {1'b0, 2'd1, 4'h0, 16'h0000, 16'h0000, 4'd2},
      {1'b1, 2'd1, 4'h4, 16'h0000, 16'h0000, 4'd4},   // R4 unmask all mailboxes
      {1'b0, 2'd1, 4'h4, 16'h0000, 16'h0000, 4'd4}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      check1("R1 irq during reset", irq, 1'b1);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][42]) begin
            bwrite(VEC[i][41:40], VEC[i][39:36], VEC[i][35:20]);
         end else begin
            bread(VEC[i][41:40], VEC[i][39:36], v);
            check16($sformatf("table %0d R%0d", i, VEC[i][3:0]), v, VEC[i][19:4]);
         end
      end

      check1("R2 irq drops after reset flag clear", irq, 1'b0);

      // R4 / R6 receive flag and summary
      @(negedge clk); rx_evt[3] = 1'b1;
      @(negedge clk); rx_evt[3] = 1'b0;
      rd_check("R4 rx flag mailbox 3", 4'h6, 16'h0008);
      rd_check("R4 rx summary bit", 4'h0, 16'h0004);
      check1("R6 masked group keeps irq low", irq, 1'b0);
      bwrite(2'd1, 4'h2, 16'h0000);
      check1("R6 unmasked group raises irq", irq, 1'b1);
      bwrite(2'd1, 4'h6, 16'h0008);
      rd_check("R7 write-1 clears rx flag", 4'h6, 16'h0000);
      check1("R7 irq low after clear", irq, 1'b0);

      // R4 masked mailbox drops events
      bwrite(2'd1, 4'h4, 16'h0020);
      @(negedge clk); txd_evt[5] = 1'b1; txc_evt[5] = 1'b1;
      @(negedge clk); txd_evt[5] = 1'b0; txc_evt[5] = 1'b0;
      rd_check("R4 masked tx done dropped", 4'h8, 16'h0000);
      rd_check("R4 masked cancel dropped", 4'hA, 16'h0000);
      check1("R4 irq stays low", irq, 1'b0);
      bwrite(2'd1, 4'h4, 16'h0000);
      rd_check("R4 no flag after unmask", 4'h8, 16'h0000);

      @(negedge clk); txd_evt[6] = 1'b1;
      @(negedge clk); txd_evt[6] = 1'b0;
      rd_check("R4 tx done mailbox 6", 4'h8, 16'h0040);
      rd_check("R4 tx summary bit", 4'h0, 16'h0008);

      // R7 set beats clear in the same cycle
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'd1; bus_addr = 4'h8; bus_wdata = 16'h0040;
      txd_evt[6] = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; txd_evt[6] = 1'b0;
      rd_check("R7 set wins over clear", 4'h8, 16'h0040);
      bwrite(2'd1, 4'h8, 16'h0040);
      rd_check("R7 later clear", 4'h8, 16'h0000);

      @(negedge clk); txc_evt[1] = 1'b1;
      @(negedge clk); txc_evt[1] = 1'b0;
      rd_check("R4 cancel mailbox 1", 4'hA, 16'h0002);
      rd_check("R4 cancel summary bit", 4'h0, 16'h0010);
      bwrite(2'd1, 4'hA, 16'h0002);

      // R4 summary bits are read-only
      @(negedge clk); rx_evt[2] = 1'b1;
      @(negedge clk); rx_evt[2] = 1'b0;
      bwrite(2'd1, 4'h0, 16'h001C);
      rd_check("R4 summary bit ignores write", 4'h0, 16'h0004);
      bwrite(2'd1, 4'h6, 16'h0004);

      // R3 bus activity, R11 status
      @(negedge clk); bus_act_evt = 1'b1;
      @(negedge clk); bus_act_evt = 1'b0;
      rd_check("R3 activity ignored when awake", 4'h0, 16'h0000);
      ctrl_sleep = 1'b1;
      @(negedge clk); bus_act_evt = 1'b1;
      @(negedge clk); bus_act_evt = 1'b0;
      rd_check("R3 activity in sleep sets flag", 4'h0, 16'h0002);
      rd_check("R11 status in sleep", 4'hC, 16'h0003);
      ctrl_sleep = 1'b0; ctrl_init = 1'b1;
      rd_check("R11 status in init", 4'hC, 16'h0001);
      ctrl_init = 1'b0;
      rd_check("R11 status idle", 4'hC, 16'h0000);

      // R5 error thresholds, R6 mask mapping
      @(negedge clk); err_warn_evt = 1'b1; err_pass_evt = 1'b1;
      @(negedge clk); err_warn_evt = 1'b0; err_pass_evt = 1'b0;
      rd_check("R5 warn and passive flags", 4'h0, 16'h0062);
      check1("R6 irq with open mask", irq, 1'b1);
      bwrite(2'd1, 4'h2, 16'h0062);
      check1("R6 irq with matching mask bits", irq, 1'b0);
      bwrite(2'd1, 4'h0, 16'h0062);
      rd_check("R7 clear several flags", 4'h0, 16'h0000);
      bwrite(2'd1, 4'h2, 16'h0000);

      // R8 DMA mode on mailbox 0
      bwrite(2'd1, 4'hE, 16'h0001);
      @(negedge clk); rx_evt[0] = 1'b1;
      @(negedge clk); rx_evt[0] = 1'b0;
      check1("R8 dma_req pulse", dma_req, 1'b1);
      @(negedge clk);
      check1("R8 dma_req one cycle", dma_req, 1'b0);
      rd_check("R8 no rx flag in DMA mode", 4'h6, 16'h0000);
      check1("R8 no irq in DMA mode", irq, 1'b0);
      bwrite(2'd1, 4'hE, 16'h0000);
      @(negedge clk); rx_evt[0] = 1'b1;
      @(negedge clk); rx_evt[0] = 1'b0;
      check1("R8 no dma_req when off", dma_req, 1'b0);
      rd_check("R8 rx flag when DMA off", 4'h6, 16'h0001);
      check1("R8 irq when DMA off", irq, 1'b1);
      bwrite(2'd1, 4'h6, 16'h0001);

      bread(2'd3, 4'h2, v);
      check16("R10 reserved size reads zero", v, 16'h0000);

      // R12 standby
      bwrite(2'd1, 4'hE, 16'h0001);
      @(negedge clk); standby = 1'b1; err_warn_evt = 1'b1;
      @(negedge clk); err_warn_evt = 1'b0;
      @(negedge clk); standby = 1'b0;
      rd_check("R12 reset flag after standby", 4'h0, 16'h0001);
      rd_check("R12 group mask default", 4'h2, 16'h007E);
      rd_check("R12 mailbox mask default", 4'h4, 16'hFFFF);
      rd_check("R12 DMA default", 4'hE, 16'h0000);
      check1("R12 irq from reset flag", irq, 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule